// File: doc/BRIEF.md
# Shift-Add Multiplier Control Sequencer

This block is the control unit of a sequential shift-and-add multiplier. It watches a start request, the zero flag of the datapath's bit counter and the low bit of the multiplier register, and issues the four strobes that drive the datapath. These strobes are: clear and preset the accumulator and counter, add the multiplicand into the accumulator, clear the carry flip-flop, and shift right while counting down. The sequencer walks through three states. The idle state waits for a start. The add state performs the conditional add. The shift state shifts and then either loops back for the next bit or returns to idle once the counter reads zero.

A parameter picks one of two builds of the same machine. In the first, a two-bit code register feeds a decoder, and the next-state equations are written directly from the decoded state lines. In the second, each state has its own flip-flop, each single-condition decision is a 1-to-2 demultiplexer, and merging paths are OR gates. Both builds present the same decoded state view and strobes in every cycle. The multiplier bit only gates the add strobe and never steers the sequence.

Top module: `mulseq_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, the sequencer is idle: `state_oh` reads 3'b001 (bit 0 idle, bit 1 add, bit 2 shift), and with `go` low every strobe is 0.
- R2: In idle with `go` low, the sequencer stays idle whatever `cnt_zero` and `mplr_bit` are. In idle with `go` high, the next clock enters the add state (`state_oh` = 3'b010).
- R3: The add state always moves to the shift state (`state_oh` = 3'b100) on the next clock, whatever `go`, `cnt_zero` and `mplr_bit` are.
- R4: In the shift state, `cnt_zero` low sends the sequencer back to the add state on the next clock, and `cnt_zero` high sends it to idle.
- R5: `init` is high in exactly the cycles where the state is idle and `go` is high, in the same cycle as `go`.
- R6: `add_en` is high in exactly the cycles where the state is add and `mplr_bit` is high.
- R7: `shift_dec` is high exactly in the shift state. `clr_carry` is high in the shift state and in idle with `go` high.
- R8: `mplr_bit` has no effect on the state sequence: the add state goes to the shift state for either value of the bit.
- R9: The encoded build (`SEQ_STYLE` = 0) and the one-flip-flop-per-state build (`SEQ_STYLE` = 1) give identical `state_oh` and strobes cycle for cycle under the same inputs, and `state_oh` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset to idle |
| go | input | 1 | Start request, sampled in idle |
| cnt_zero | input | 1 | Datapath bit counter reads zero, sampled in the shift state |
| mplr_bit | input | 1 | Current low bit of the multiplier register |
| init | output | 1 | Clear accumulator and preset counter |
| add_en | output | 1 | Load accumulator with sum and capture carry |
| clr_carry | output | 1 | Clear the carry flip-flop |
| shift_dec | output | 1 | Shift carry, accumulator and multiplier right and decrement the counter |
| state_oh | output | 3 | Decoded state: bit 0 idle, bit 1 add, bit 2 shift |

## Verification
Both builds run side by side against a bench reference model. Directed runs come first. Idle is held with `go` low while `cnt_zero` and `mplr_bit` toggle, which shows that those two inputs are ignored there. Full passes follow, with the add state visited under both values of `mplr_bit`, which separates the strobe gating from the next-state path. The shift state is entered with `cnt_zero` low and with it high, which separates the loop-back branch from the return to idle. A long constrained-random stretch follows, with `go` and `cnt_zero` skewed toward rarity so that multi-bit loops occur. In every cycle each build is compared with the model and with the other build, so a fault in only one build's next-state or output logic shows up as a disagreement between them.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

   // build selection values for SEQ_STYLE
   localparam int unsigned SEQ_ENCODED = 0;
   localparam int unsigned SEQ_ONEHOT  = 1;

   // state counts and widths
   localparam int unsigned N_STATES = 3;
   localparam int unsigned CODE_W   = $clog2(N_STATES);

   // positions in the decoded state vector
   localparam int unsigned OH_IDLE = 0;
   localparam int unsigned OH_ADD  = 1;
   localparam int unsigned OH_SHF  = 2;

   // encoded state codes, high bit first; the fourth code is unused
   typedef enum logic [CODE_W-1:0] {
      CODE_IDLE = 2'b00,
      CODE_ADD  = 2'b01,
      CODE_SHF  = 2'b10
   } st_code_e;

endpackage

// File: rtl/mulseq_demux2.sv
// 1-to-2 demultiplexer: routes the enable onto the branch chosen by sel.
module mulseq_demux2 (
   input  logic en,
   input  logic sel,
   output logic out0,
   output logic out1
);
   always_comb begin
      out0 = en & ~sel;
      out1 = en &  sel;
   end
endmodule

// File: rtl/mulseq_enc_seq.sv
// Encoded build: code register followed by a decoder.
module mulseq_enc_seq
   import mulseq_pkg::*;
#(
   parameter int unsigned NS = N_STATES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          cnt_zero,
   output logic [NS-1:0] st_oh
);
   localparam int unsigned CW = $clog2(NS);

   logic [CW-1:0] code_q;
   logic          hi_d, lo_d;

   // decoder; the unused code decodes to no state at all
   always_comb begin
      st_oh          = '0;
      st_oh[OH_IDLE] = (code_q == CODE_IDLE);
      st_oh[OH_ADD]  = (code_q == CODE_ADD);
      st_oh[OH_SHF]  = (code_q == CODE_SHF);
   end

   // next-state bits from the decoded lines; with no line active both
   // bits are zero, so the unused code falls back to idle on the next edge
   always_comb begin
      hi_d = st_oh[OH_ADD];
      lo_d = (st_oh[OH_IDLE] & go) | (st_oh[OH_SHF] & ~cnt_zero);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) code_q <= CODE_IDLE;
      else        code_q <= {hi_d, lo_d};
   end
endmodule

// File: rtl/mulseq_oh_seq.sv
// One flip-flop per state, built from demultiplexers and OR junctions.
module mulseq_oh_seq
   import mulseq_pkg::*;
#(
   parameter int unsigned NS = N_STATES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          cnt_zero,
   output logic [NS-1:0] st_oh
);
   logic [NS-1:0] st_q;
   logic [NS-1:0] st_d;
   logic          idle_wait, idle_start, shf_loop, shf_done;

   // decision on go, entered from idle
   mulseq_demux2 i_go_dmx (
      .en   (st_q[OH_IDLE]),
      .sel  (go),
      .out0 (idle_wait),
      .out1 (idle_start)
   );

   // decision on counter zero, entered from the shift state
   mulseq_demux2 i_zero_dmx (
      .en   (st_q[OH_SHF]),
      .sel  (cnt_zero),
      .out0 (shf_loop),
      .out1 (shf_done)
   );

   // junctions
   always_comb begin
      st_d          = '0;
      st_d[OH_IDLE] = idle_wait | shf_done;
      st_d[OH_ADD]  = idle_start | shf_loop;
      st_d[OH_SHF]  = st_q[OH_ADD];
   end

   // one D flip-flop per state; only idle is set by reset
   for (genvar g = 0; g < NS; g++) begin : g_ff
      localparam logic RST_VAL = (g == OH_IDLE);
      always_ff @(posedge clk) begin
         if (!rst_n) st_q[g] <= RST_VAL;
         else        st_q[g] <= st_d[g];
      end
   end

   assign st_oh = st_q;
endmodule

// File: rtl/mulseq_strobes.sv
// Control strobes from the decoded state (shared by both builds).
module mulseq_strobes
   import mulseq_pkg::*;
#(
   parameter int unsigned NS = N_STATES
) (
   input  logic [NS-1:0] st_oh,
   input  logic          go,
   input  logic          mplr_bit,
   output logic          init,
   output logic          add_en,
   output logic          clr_carry,
   output logic          shift_dec
);
   logic start;

   always_comb begin
      start     = st_oh[OH_IDLE] & go;
      init      = start;
      add_en    = st_oh[OH_ADD] & mplr_bit;
      clr_carry = start | st_oh[OH_SHF];
      shift_dec = st_oh[OH_SHF];
   end
endmodule

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl
   import mulseq_pkg::*;
#(
   parameter int unsigned SEQ_STYLE = SEQ_ENCODED
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic                cnt_zero,
   input  logic                mplr_bit,
   output logic                init,
   output logic                add_en,
   output logic                clr_carry,
   output logic                shift_dec,
   output logic [N_STATES-1:0] state_oh
);
   logic [N_STATES-1:0] st_w;

   initial begin : p_param_chk
      if (SEQ_STYLE != SEQ_ENCODED && SEQ_STYLE != SEQ_ONEHOT)
         $error("mulseq_ctrl: SEQ_STYLE must be 0 or 1, got %0d", SEQ_STYLE);
   end

   if (SEQ_STYLE == SEQ_ONEHOT) begin : g_onehot
      mulseq_oh_seq #(.NS(N_STATES)) i_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .go       (go),
         .cnt_zero (cnt_zero),
         .st_oh    (st_w)
      );
   end else begin : g_encoded
      mulseq_enc_seq #(.NS(N_STATES)) i_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .go       (go),
         .cnt_zero (cnt_zero),
         .st_oh    (st_w)
      );
   end

   mulseq_strobes #(.NS(N_STATES)) i_strb (
      .st_oh     (st_w),
      .go        (go),
      .mplr_bit  (mplr_bit),
      .init      (init),
      .add_en    (add_en),
      .clr_carry (clr_carry),
      .shift_dec (shift_dec)
   );

   assign state_oh = st_w;
endmodule

// File: rtl/mulseq_ctrl_chk.sv
module mulseq_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       go,
   input logic       cnt_zero,
   input logic       mplr_bit,
   input logic       init,
   input logic       add_en,
   input logic       clr_carry,
   input logic       shift_dec,
   input logic [2:0] state_oh
);
   // R1: reset lands in idle
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> state_oh == 3'b001);

   // R2
   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      state_oh[0] && !go |=> state_oh == 3'b001);
   a_r2_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
      state_oh[0] && go |=> state_oh == 3'b010);

   // R3
   a_r3_add_to_shift: assert property (@(posedge clk) disable iff (!rst_n)
      state_oh[1] |=> state_oh == 3'b100);

   // R4
   a_r4_shift_loop: assert property (@(posedge clk) disable iff (!rst_n)
      state_oh[2] && !cnt_zero |=> state_oh == 3'b010);
   a_r4_shift_done: assert property (@(posedge clk) disable iff (!rst_n)
      state_oh[2] && cnt_zero |=> state_oh == 3'b001);

   // R5
   a_r5_init_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      init |-> state_oh[0] && go);

   // R6
   a_r6_add_gated: assert property (@(posedge clk) disable iff (!rst_n)
      add_en |-> state_oh[1] && mplr_bit);

   // R7
   a_r7_shift_clears: assert property (@(posedge clk) disable iff (!rst_n)
      shift_dec |-> clr_carry && state_oh[2]);

   // R9
   a_r9_one_state: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(state_oh) == 1);
endmodule

bind mulseq_ctrl mulseq_ctrl_chk i_mulseq_ctrl_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .go        (go),
   .cnt_zero  (cnt_zero),
   .mplr_bit  (mplr_bit),
   .init      (init),
   .add_en    (add_en),
   .clr_carry (clr_carry),
   .shift_dec (shift_dec),
   .state_oh  (state_oh)
);

// File: tb/test_mulseq_ctrl.sv
`timescale 1ns/1ps
module test_mulseq_ctrl;

   localparam logic [2:0] S_IDLE = 3'b001;
   localparam logic [2:0] S_ADD  = 3'b010;
   localparam logic [2:0] S_SHF  = 3'b100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic go = 1'b0, cnt_zero = 1'b0, mplr_bit = 1'b0;

   logic       e_init, e_add, e_clr, e_shf;
   logic [2:0] e_st;
   logic       o_init, o_add, o_clr, o_shf;
   logic [2:0] o_st;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [2:0] m_st = S_IDLE;
   string      st_tag = "R1";

   always #2.5 clk = ~clk;

   mulseq_ctrl #(.SEQ_STYLE(0)) i_mulseq_ctrl (
      .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero), .mplr_bit(mplr_bit),
      .init(e_init), .add_en(e_add), .clr_carry(e_clr), .shift_dec(e_shf), .state_oh(e_st));

   mulseq_ctrl #(.SEQ_STYLE(1)) i_mulseq_ctrl_oh (
      .clk(clk), .rst_n(rst_n), .go(go), .cnt_zero(cnt_zero), .mplr_bit(mplr_bit),
      .init(o_init), .add_en(o_add), .clr_carry(o_clr), .shift_dec(o_shf), .state_oh(o_st));

   function automatic logic [2:0] nxt(input logic [2:0] s, input logic g, input logic z);
      case (s)
         S_IDLE:  return g ? S_ADD : S_IDLE;
         S_ADD:   return S_SHF;
         S_SHF:   return z ? S_IDLE : S_ADD;
         default: return S_IDLE;
      endcase
   endfunction

   // {init, add_en, clr_carry, shift_dec}
   function automatic logic [3:0] strobes(input logic [2:0] s, input logic g, input logic q);
      logic st;
      st = (s == S_IDLE) && g;
      return {st, (s == S_ADD) && q, st || (s == S_SHF), s == S_SHF};
   endfunction

   task automatic chk(input string tag, input string what, input logic [6:0] act, input logic [6:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %b expected %b (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_now(input string build, input logic [2:0] st,
                            input logic i, input logic a, input logic c, input logic s);
      logic [3:0] ex;
      ex = strobes(m_st, go, mplr_bit);
      chk(st_tag, {build, " state"}, {4'b0, st}, {4'b0, m_st});
      chk("R5", {build, " init"}, {6'b0, i}, {6'b0, ex[3]});
      chk("R6", {build, " add_en"}, {6'b0, a}, {6'b0, ex[2]});
      chk("R7", {build, " clr_carry"}, {6'b0, c}, {6'b0, ex[1]});
      chk("R7", {build, " shift_dec"}, {6'b0, s}, {6'b0, ex[0]});
   endtask

   // one cycle: drive at negedge, check shortly after, advance model at posedge
   task automatic step(input logic g, input logic z, input logic q, input string force_tag);
      logic [2:0] ns;
      @(negedge clk);
      go = g; cnt_zero = z; mplr_bit = q;
      #1;
      check_now("enc", e_st, e_init, e_add, e_clr, e_shf);
      check_now("oh",  o_st, o_init, o_add, o_clr, o_shf);
      chk("R9", "builds agree", {e_st, e_init, e_add, e_clr, e_shf},
                                {o_st, o_init, o_add, o_clr, o_shf});
      ns = nxt(m_st, g, z);
      @(posedge clk);
      if (force_tag != "") st_tag = force_tag;
      else if (m_st == S_IDLE) st_tag = "R2";
      else if (m_st == S_ADD)  st_tag = "R3";
      else                     st_tag = "R4";
      m_st = ns;
   endtask

   initial begin : p_watchdog
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, got hung expected done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : p_main
      void'($urandom(32'd20240917));
      // R1: during reset
      repeat (3) @(posedge clk);
      #1;
      chk("R1", "enc state in reset", {4'b0, e_st}, {4'b0, S_IDLE});
      chk("R1", "oh state in reset",  {4'b0, o_st}, {4'b0, S_IDLE});
      chk("R1", "enc strobes in reset", {3'b0, e_init, e_add, e_clr, e_shf}, 7'b0);
      chk("R1", "oh strobes in reset",  {3'b0, o_init, o_add, o_clr, o_shf}, 7'b0);
      @(negedge clk);
      rst_n = 1'b1;
      m_st = S_IDLE;
      st_tag = "R1";

      // R2: idle ignores counter zero and multiplier bit
      step(0, 1, 1, "R2");
      step(0, 0, 1, "R2");
      step(0, 1, 0, "R2");
      // start, add with bit set and noisy go/zero (R3, R6)
      step(1, 1, 0, "");
      step(1, 1, 1, "R8");
      // shift with zero low: loop back (R4)
      step(1, 0, 1, "");
      // add with bit clear (R6, R8)
      step(0, 0, 0, "R8");
      // shift with zero high: back to idle (R4)
      step(0, 1, 0, "");
      step(0, 0, 0, "");
      // three-bit pass
      step(1, 0, 0, "");
      for (int b = 0; b < 3; b++) begin
         step($urandom_range(0, 1), $urandom_range(0, 1), b[0], "R8");
         step(0, b == 2, 1, "");
      end
      step(0, 0, 0, "");

      // constrained random
      for (int k = 0; k < 3000; k++) begin
         step(($urandom % 4) == 0, ($urandom % 3) == 0, $urandom_range(0, 1), "");
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule